// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Fall-Through Output

This block is a first-in first-out buffer whose write side and read side each run on their own clock. Pointers cross between the two clocks as Gray code through two-stage synchronizers. Each status output is derived only in the clock domain that uses it.

The read timing style is chosen once, at master reset, from the level of `fwft_sel`. In standard mode every word must be requested with `rd_en`. In that mode `rd_flag` reports empty and `wr_flag` reports full. In fall-through mode the oldest stored word is moved without any request into an output register. That register is refilled from memory whenever it is consumed or empty. In this mode `rd_flag` means "a valid word is on `rd_data`" and `wr_flag` means "a write will be accepted". Because of these ready signals, one buffer's outputs can feed the next buffer's inputs directly.

A partial reset empties the buffer and keeps the latched mode. A rewind input sets the read position back to the first memory location so stored data can be read again.

Top module: `dual_mode_fifo`

## Requirements
- R1: The read mode is captured from `fwft_sel` while `master_rst` is high: 1 selects fall-through mode and 0 selects standard mode. The captured mode holds until the next master reset, and `fwft_sel` has no effect at any other time.
- R2: In standard mode, `rd_flag` is 1 exactly when no unread word is stored, and `wr_flag` is 1 exactly when DEPTH words are stored.
- R3: In standard mode, `rd_en` high at a rising `rd_clk` edge while `rd_flag` is 0 places the next stored word on `rd_data` after that edge, in write order.
- R4: In fall-through mode, a word written into an empty buffer appears on `rd_data`, with `rd_flag` rising to 1, after the third rising `rd_clk` edge that follows the write edge. No `rd_en` is needed for this.
- R5: In fall-through mode, the presented word stays on `rd_data` while `rd_en` is low. `rd_en` high at an edge while `rd_flag` is 1 consumes the word. After that edge the next stored word is presented, or `rd_flag` drops to 0 if none is stored.
- R6: In fall-through mode, `wr_flag` is 1 while memory has a free location and 0 when all DEPTH locations hold words.
- R7: A write attempted while memory holds DEPTH words is discarded. Later reads return only the words that were accepted.
- R8: In standard mode, `rd_en` while the buffer is empty has no effect: `rd_data` keeps its value and later reads return the words written afterwards.
- R9: A partial reset empties the buffer and leaves the captured mode unchanged. Both flags then read as for an empty buffer in that mode.
- R10: A master reset empties the buffer and clears `rd_data` to 0. In standard mode it sets `rd_flag`=1 and `wr_flag`=0; in fall-through mode it sets `rd_flag`=0 and `wr_flag`=1.
- R11: `rd_rewind` high at a rising `rd_clk` edge sets the read position to the first memory location. Reads then repeat from the first word written since the last reset. In fall-through mode the output register is refilled with that word. This is valid when no more than DEPTH words have been written since that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| master_rst | input | 1 | Synchronous active-high full reset; captures the mode (held across edges of both clocks) |
| partial_rst | input | 1 | Synchronous active-high pointer reset that keeps the mode |
| fwft_sel | input | 1 | Mode select sampled during master reset (1 = fall-through) |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write word |
| wr_flag | output | 1 | Full (standard mode) or input ready (fall-through mode) |
| rd_en | input | 1 | Read request / consume strobe |
| rd_rewind | input | 1 | Rewind read position to the first location |
| rd_data | output | DATA_W | Read word |
| rd_flag | output | 1 | Empty (standard mode) or output ready (fall-through mode) |

## Verification
A read pointer that advances wrongly shows up as a skipped or repeated word at the next read or refill edge. A stuck synchronizer stage or an off-by-one Gray compare shows up as a flag that never changes, or as a fall-through latency other than three read edges. A mode register that follows `fwft_sel` after reset flips the meaning of both flags, which can be seen on the first flag sample after the change. A partial reset that loses the mode shows up the same way. A write pointer that advances while full corrupts the word order after wrap, which the readback of a full buffer exposes DEPTH reads later.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        for (int i = 1; i < 32; i++) begin
            b = b ^ (g >> i);
        end
        return b;
    endfunction

endpackage

// File: rtl/dmf_sync.sv
module dmf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dmf_mem.sv
module dmf_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[raddr];
        end
    end
endmodule

// File: rtl/dmf_wr_ctrl.sv
module dmf_wr_ctrl
    import dmf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_master,
    input  logic          rst_part,
    input  logic          mode_sel,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_sync,
    output logic          mem_we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          wr_flag
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

    rd_mode_e    mode;
    logic        rst;
    logic        full;
    logic        accept;
    logic [AW:0] wbin;
    logic [AW:0] wbin_nxt;
    logic [AW:0] rsync_bin;

    assign rst       = rst_master | rst_part;
    assign full      = (wgray == {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]});
    assign accept    = wr_en && !full;
    assign wbin_nxt  = wbin + 1'b1;
    assign rsync_bin = PW'(gray2bin(32'(rgray_sync)));

    always_ff @(posedge clk) begin
        if (rst_master) begin
            mode <= rd_mode_e'(mode_sel);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (accept) begin
            wbin  <= wbin_nxt;
            wgray <= PW'(bin2gray(32'(wbin_nxt)));
        end
    end

    assign mem_we  = accept;
    assign waddr   = wbin[AW-1:0];
    assign wr_flag = (mode == MODE_STD) ? full : !full;

    assert_mode_hold_w_R1: assert property (@(posedge clk) disable iff (rst_master)
        1'b1 |=> $stable(mode));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (PW'(wbin - rsync_bin) <= DEPTH));

    assert_full_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_flag == (mode == MODE_STD)) |=> $stable(wbin));

    assert_wptr_cleared_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wbin == '0));
endmodule

// File: rtl/dmf_rd_ctrl.sv
module dmf_rd_ctrl
    import dmf_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_master,
    input  logic          rst_part,
    input  logic          mode_sel,
    input  logic          rd_en,
    input  logic          rewind,
    input  logic [AW:0]   wgray_sync,
    input  logic [DW-1:0] rd_data,
    output logic          mem_re,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          rd_flag
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

    rd_mode_e    mode;
    logic        rst;
    logic        empty;
    logic        fetch;
    logic        ovalid;
    logic [AW:0] rbin;
    logic [AW:0] rbin_nxt;
    logic [AW:0] wsync_bin;

    assign rst       = rst_master | rst_part;
    assign empty     = (rgray == wgray_sync);
    assign rbin_nxt  = rbin + 1'b1;
    assign wsync_bin = PW'(gray2bin(32'(wgray_sync)));

    always_comb begin
        if (mode == MODE_FWFT) begin
            fetch = !empty && (!ovalid || rd_en);
        end else begin
            fetch = !empty && rd_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_master) begin
            mode <= rd_mode_e'(mode_sel);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin   <= '0;
            rgray  <= '0;
            ovalid <= 1'b0;
        end else if (rewind) begin
            rbin   <= '0;
            rgray  <= '0;
            ovalid <= 1'b0;
        end else begin
            if (fetch) begin
                rbin  <= rbin_nxt;
                rgray <= PW'(bin2gray(32'(rbin_nxt)));
            end
            if (mode == MODE_FWFT) begin
                if (fetch) begin
                    ovalid <= 1'b1;
                end else if (rd_en) begin
                    ovalid <= 1'b0;
                end
            end
        end
    end

    assign mem_re  = fetch && !rewind;
    assign raddr   = rbin[AW-1:0];
    assign rd_flag = (mode == MODE_STD) ? empty : ovalid;

    assert_mode_hold_r_R1: assert property (@(posedge clk) disable iff (rst_master)
        1'b1 |=> $stable(mode));

    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        (PW'(wsync_bin - rbin) <= DEPTH));

    assert_fwft_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FWFT && ovalid && !rd_en && !rewind) |=> (ovalid && $stable(rd_data)));

    assert_rewind_restart_R11: assert property (@(posedge clk) disable iff (rst)
        rewind |=> (rbin == '0));
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              master_rst,
    input  logic              partial_rst,
    input  logic              fwft_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_flag,
    input  logic              rd_en,
    input  logic              rd_rewind,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag
);
    localparam int PW = ADDR_W + 1;

    logic              any_rst;
    logic              mem_we;
    logic              mem_re;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     wgray_at_rd;
    logic [PW-1:0]     rgray_at_wr;

    assign any_rst = master_rst | partial_rst;

    dmf_wr_ctrl #(.AW(ADDR_W)) wr_ctrl_i (
        .clk        (wr_clk),
        .rst_master (master_rst),
        .rst_part   (partial_rst),
        .mode_sel   (fwft_sel),
        .wr_en      (wr_en),
        .rgray_sync (rgray_at_wr),
        .mem_we     (mem_we),
        .waddr      (waddr),
        .wgray      (wgray),
        .wr_flag    (wr_flag)
    );

    dmf_rd_ctrl #(.AW(ADDR_W), .DW(DATA_W)) rd_ctrl_i (
        .clk        (rd_clk),
        .rst_master (master_rst),
        .rst_part   (partial_rst),
        .mode_sel   (fwft_sel),
        .rd_en      (rd_en),
        .rewind     (rd_rewind),
        .wgray_sync (wgray_at_rd),
        .rd_data    (rd_data),
        .mem_re     (mem_re),
        .raddr      (raddr),
        .rgray      (rgray),
        .rd_flag    (rd_flag)
    );

    dmf_sync #(.W(PW)) w2r_sync_i (
        .clk (rd_clk),
        .rst (any_rst),
        .d   (wgray),
        .q   (wgray_at_rd)
    );

    dmf_sync #(.W(PW)) r2w_sync_i (
        .clk (wr_clk),
        .rst (any_rst),
        .d   (rgray),
        .q   (rgray_at_wr)
    );

    dmf_mem #(.DW(DATA_W), .AW(ADDR_W)) mem_i (
        .wclk  (wr_clk),
        .we    (mem_we),
        .waddr (waddr),
        .wdata (wr_data),
        .rclk  (rd_clk),
        .rrst  (any_rst),
        .re    (mem_re),
        .raddr (raddr),
        .rdata (rd_data)
    );
endmodule

// File: tb/dual_mode_fifo_tb_top.sv
`timescale 1ns/10ps
module dual_mode_fifo_tb_top;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          master_rst = 1'b1;
    logic          partial_rst = 1'b0;
    logic          fwft_sel = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_flag;
    logic          rd_en = 1'b0;
    logic          rd_rewind = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 wr_clk = ~wr_clk;
    always #3.6 rd_clk = ~rd_clk;

    dual_mode_fifo #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .wr_clk      (wr_clk),
        .rd_clk      (rd_clk),
        .master_rst  (master_rst),
        .partial_rst (partial_rst),
        .fwft_sel    (fwft_sel),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .wr_flag     (wr_flag),
        .rd_en       (rd_en),
        .rd_rewind   (rd_rewind),
        .rd_data     (rd_data),
        .rd_flag     (rd_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_master(input logic sel);
        @(negedge wr_clk);
        master_rst <= 1'b1;
        fwft_sel   <= sel;
        repeat (6) @(negedge wr_clk);
        master_rst <= 1'b0;
        repeat (4) @(negedge rd_clk);
    endtask

    task automatic do_partial(input logic sel_noise);
        @(negedge wr_clk);
        partial_rst <= 1'b1;
        fwft_sel    <= sel_noise;
        repeat (6) @(negedge wr_clk);
        partial_rst <= 1'b0;
        repeat (4) @(negedge rd_clk);
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en   <= 1'b1;
        wr_data <= d;
        @(negedge wr_clk);
        wr_en   <= 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic [DW-1:0] exp);
        @(negedge rd_clk);
        rd_en <= 1'b1;
        @(posedge rd_clk);
        #1;
        chk(req, 32'(rd_data), 32'(exp));
        @(negedge rd_clk);
        rd_en <= 1'b0;
    endtask

    task automatic rewind_pulse();
        @(negedge rd_clk);
        rd_rewind <= 1'b1;
        @(negedge rd_clk);
        rd_rewind <= 1'b0;
    endtask

    task automatic wait_rd_flag(input logic val);
        for (int i = 0; i < 20; i++) begin
            if (rd_flag === val) break;
            @(posedge rd_clk);
            #1;
        end
    endtask

    // R10, R2: standard-mode reset state; R1: fwft_sel changed after reset
    task automatic t_reset_std();
        do_master(1'b0);
        fwft_sel <= 1'b1;
        #1;
        chk("R10 std rd_flag", 32'(rd_flag), 32'd1);
        chk("R10 std wr_flag", 32'(wr_flag), 32'd0);
        chk("R10 rd_data cleared", 32'(rd_data), 32'd0);
    endtask

    // R8: reads on empty ignored; R3/R2 single word
    task automatic t_empty_read();
        @(negedge rd_clk);
        rd_en <= 1'b1;
        repeat (3) @(negedge rd_clk);
        rd_en <= 1'b0;
        #1;
        chk("R8 rd_data unchanged", 32'(rd_data), 32'd0);
        chk("R8 still empty", 32'(rd_flag), 32'd1);
        push(8'hA5);
        wait_rd_flag(1'b0);
        chk("R2 not empty after write", 32'(rd_flag), 32'd0);
        chk("R1 no fall-through in std", 32'(rd_data), 32'd0);
        pop_expect("R8 first real read", 8'hA5);
        chk("R2 empty after read", 32'(rd_flag), 32'd1);
    endtask

    // R2/R7/R3: fill, overflow attempts, in-order drain
    task automatic t_full_std();
        for (int i = 0; i < DEPTH; i++) push(8'(8'h40 + i));
        chk("R2 full flag", 32'(wr_flag), 32'd1);
        push(8'hEE);
        push(8'hEF);
        chk("R7 still full", 32'(wr_flag), 32'd1);
        repeat (6) @(posedge rd_clk);
        for (int i = 0; i < DEPTH; i++) pop_expect("R3 order", 8'(8'h40 + i));
        chk("R7 extra writes dropped", 32'(rd_flag), 32'd1);
        repeat (8) @(negedge wr_clk);
        chk("R2 not full after drain", 32'(wr_flag), 32'd0);
    endtask

    // R9 partial reset in std; R11 rewind in std
    task automatic t_partial_std();
        push(8'h01);
        push(8'h02);
        push(8'h03);
        repeat (6) @(posedge rd_clk);
        do_partial(1'b1);
        #1;
        chk("R9 std empty", 32'(rd_flag), 32'd1);
        chk("R9 std not full", 32'(wr_flag), 32'd0);
        for (int i = 0; i < 4; i++) push(8'(8'hB0 + i));
        repeat (6) @(posedge rd_clk);
        #1;
        chk("R9 mode kept std", 32'(rd_data), 32'd0);
        pop_expect("R3 pre-rewind", 8'hB0);
        pop_expect("R3 pre-rewind", 8'hB1);
        rewind_pulse();
        for (int i = 0; i < 4; i++) pop_expect("R11 std replay", 8'(8'hB0 + i));
        chk("R11 std empty after replay", 32'(rd_flag), 32'd1);
    endtask

    // R10/R1: fall-through reset state
    task automatic t_reset_fwft();
        do_master(1'b1);
        fwft_sel <= 1'b0;
        #1;
        chk("R10 fwft rd_flag", 32'(rd_flag), 32'd0);
        chk("R10 fwft wr_flag", 32'(wr_flag), 32'd1);
    endtask

    // R4 latency, R5 hold and consume
    task automatic t_fall_through();
        int cnt;
        @(negedge wr_clk);
        wr_en   <= 1'b1;
        wr_data <= 8'hC0;
        @(posedge wr_clk);
        wr_en <= 1'b0;
        cnt = 0;
        while (cnt < 10 && rd_flag !== 1'b1) begin
            @(posedge rd_clk);
            #1;
            cnt++;
        end
        chk("R4 latency edges", 32'(cnt), 32'd3);
        chk("R4 word presented", 32'(rd_data), 32'hC0);
        repeat (5) @(posedge rd_clk);
        #1;
        chk("R5 held", 32'(rd_data), 32'hC0);
        chk("R5 ready held", 32'(rd_flag), 32'd1);
        push(8'hC1);
        push(8'hC2);
        repeat (6) @(posedge rd_clk);
        pop_expect("R5 next word", 8'hC1);
        pop_expect("R5 next word", 8'hC2);
        @(negedge rd_clk);
        rd_en <= 1'b1;
        @(posedge rd_clk);
        #1;
        chk("R5 ready drops", 32'(rd_flag), 32'd0);
        @(negedge rd_clk);
        rd_en <= 1'b0;
    endtask

    // R6/R7 in fall-through
    task automatic t_fwft_full();
        push(8'hD0);
        repeat (8) @(posedge rd_clk);
        for (int i = 0; i < DEPTH; i++) push(8'(8'h60 + i));
        chk("R6 input not ready", 32'(wr_flag), 32'd0);
        push(8'hFF);
        repeat (6) @(posedge rd_clk);
        #1;
        chk("R6 output word", 32'(rd_data), 32'hD0);
        for (int i = 0; i < DEPTH; i++) pop_expect("R7 fwft order", 8'(8'h60 + i));
        @(negedge rd_clk);
        rd_en <= 1'b1;
        @(posedge rd_clk);
        #1;
        chk("R7 fwft overflow dropped", 32'(rd_flag), 32'd0);
        @(negedge rd_clk);
        rd_en <= 1'b0;
        repeat (8) @(negedge wr_clk);
        chk("R6 input ready again", 32'(wr_flag), 32'd1);
    endtask

    // R9 partial in fwft, R11 rewind in fwft
    task automatic t_partial_fwft();
        push(8'h77);
        repeat (6) @(posedge rd_clk);
        do_partial(1'b0);
        #1;
        chk("R9 fwft not ready", 32'(rd_flag), 32'd0);
        chk("R9 fwft input ready", 32'(wr_flag), 32'd1);
        push(8'hE0);
        push(8'hE1);
        push(8'hE2);
        wait_rd_flag(1'b1);
        chk("R9 mode kept fwft", 32'(rd_data), 32'hE0);
        pop_expect("R5 pre-rewind", 8'hE1);
        rewind_pulse();
        repeat (3) @(posedge rd_clk);
        #1;
        chk("R11 fwft refill", 32'(rd_data), 32'hE0);
        chk("R11 fwft ready", 32'(rd_flag), 32'd1);
        pop_expect("R11 fwft replay", 8'hE1);
        pop_expect("R11 fwft replay", 8'hE2);
        @(negedge rd_clk);
        rd_en <= 1'b1;
        @(posedge rd_clk);
        #1;
        chk("R11 fwft end", 32'(rd_flag), 32'd0);
        @(negedge rd_clk);
        rd_en <= 1'b0;
    endtask

    initial begin
        t_reset_std();
        t_empty_read();
        t_full_std();
        t_partial_std();
        t_reset_fwft();
        t_fall_through();
        t_fwft_full();
        t_partial_fwft();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule